// File: doc/BRIEF.md
# Sticky Interrupt Flag Controller with Clear-on-Read Status

This block gathers single-cycle event pulses from three interrupt sources: an alarm match, a periodic tick and the end of a time-keeping update. It keeps each pulse as a sticky flag. The flags and a summary bit can be read through a status register. An active-low interrupt request is asserted whenever a flag and its enable bit are both set. The flags are set whether or not the source is enabled, so software can either poll the status register or take interrupts.

A status read is a one-cycle strobe. On that strobe the block captures the flags and the summary bit into a holding register, and it clears every flag at the same clock edge. The captured value stays on the read-data port until the next read. An event that arrives while the read strobe is high does not go into the captured value. It goes into a pending register and becomes a flag on the first clock edge that has no read strobe. Such an event therefore shows up in the next read and is never dropped.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, irq_n is 1, rd_data is 0x00, every flag is clear and every enable is clear.
- R2: An event pulse sets its flag even when its enable is 0. A later read reports the flag while irq_n stays 1.
- R3: irq_n is 0 exactly while at least one source has both its flag and its enable set. It falls in the cycle after the edge that samples an enabled event.
- R4: Bit 7 of rd_data is 1 exactly when irq_n was 0 during the cycle of the read strobe.
- R5: The edge that samples rd_stb clears every flag at once. With nothing pending, irq_n is 1 from then on.
- R6: rd_data changes only at an edge that samples rd_stb. Events and enable writes between reads leave it unchanged.
- R7: An event sampled together with rd_stb is left out of that read's value. It becomes a flag one cycle later, so an enabled source then drives irq_n to 0, and the next read reports it.
- R8: Several flags can be set at the same time, and a single read reports them all.
- R9: Writing an enable for a source whose flag is already set drives irq_n to 0 in the cycle after the write, even though the event came earlier.
- R10: The field positions are the same in the enable register (wr_data) and in rd_data: bit 6 is periodic, bit 5 is alarm and bit 4 is update-ended. rd_data bits 3:0 always read 0.
- R11: While rd_stb stays high over consecutive cycles, events keep building up in the pending register. They are merged into the flags on the first edge after rd_stb goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_update | input | 1 | Update-ended event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_periodic | input | 1 | Periodic event pulse |
| wr_en | input | 1 | Enable-register write strobe |
| wr_data | input | 8 | Enable-register write data (bits 6:4 used) |
| rd_stb | input | 1 | Status read strobe, one cycle per read |
| rd_data | output | 8 | Captured status value from the last read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check these rules on every cycle:
- an enabled event that is sampled outside a read pulls irq_n low in the next cycle;
- a read with nothing pending releases irq_n;
- rd_data holds its value between reads;
- the summary bit matches the pin level at the read;
- an event that lands on a read goes into the pending register.

The bench scenarios cover what a single property cannot follow across several reads:
- flags that are only polled;
- a late enable picking up an old flag;
- several flags reported in one read;
- a deferred event appearing in the following read;
- events held over a run of back-to-back read strobes.

// File: rtl/irq_flag_pkg.sv
// Package: shared constants and source indices for the interrupt flag controller.
// Assumes the source field sits directly below the summary bit.
package irq_flag_pkg;
    localparam int NUM_SRC  = 3;
    localparam int DATA_W   = 8;
    localparam int FLAG_LSB = 4;
    localparam int IRQF_BIT = 7;

    typedef enum int {
        SRC_UPDATE   = 0,
        SRC_ALARM    = 1,
        SRC_PERIODIC = 2
    } src_idx_e;
endpackage

// File: rtl/irq_src_cell.sv
// Module: one source's sticky flag plus a pending latch for events that arrive
// during a read. Assumes ev is a one-cycle pulse and rd_stb marks a read cycle.
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic rd_stb,
    output logic flag_o,
    output logic pend_o
);
    logic flag_q;
    logic pend_q;

    // Flag/pending update: a read clears the flag and holds new events back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (rd_stb) begin
            flag_q <= 1'b0;
            pend_q <= pend_q | ev;
        end else begin
            flag_q <= flag_q | pend_q | ev;
            pend_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/irq_en_reg.sv
// Module: host-written enable register. Takes the source field out of the write
// data. Assumes the field starts at bit LSB and that LSB+NUM_SRC <= DATA_W.
module irq_en_reg #(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 3,
    parameter int LSB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] en_q;

    // Enable capture: load the source field on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= wr_data[LSB +: NUM_SRC];
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_status_snap.sv
// Module: status holding register. Captures the summary bit and the flags on a
// read strobe and keeps them until the next read. Unused bits read as 0.
module irq_status_snap #(
    parameter int DATA_W   = 8,
    parameter int NUM_SRC  = 3,
    parameter int LSB      = 4,
    parameter int IRQF_POS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic               irq_act,
    input  logic [NUM_SRC-1:0] flags,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] snap_d;
    logic [DATA_W-1:0] snap_q;

    // Status word assembly: place the flags and the summary bit.
    always_comb begin
        snap_d = '0;
        snap_d[LSB +: NUM_SRC] = flags;
        snap_d[IRQF_POS] = irq_act;
    end

    // Capture: take the snapshot only at the edge that samples the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (rd_stb)
            snap_q <= snap_d;
    end

    assign rd_data = snap_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: top of the interrupt flag controller. One cell per source, the
// enable register, the status holding register and the active-low request.
// Assumes the event inputs and strobes are synchronous to clk.
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int P_NUM_SRC  = NUM_SRC,
    parameter int P_DATA_W   = DATA_W,
    parameter int P_FLAG_LSB = FLAG_LSB,
    parameter int P_IRQF_BIT = IRQF_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_update,
    input  logic                ev_alarm,
    input  logic                ev_periodic,
    input  logic                wr_en,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic                rd_stb,
    output logic [P_DATA_W-1:0] rd_data,
    output logic                irq_n
);
    logic [P_NUM_SRC-1:0] ev_vec;
    logic [P_NUM_SRC-1:0] flag_vec;
    logic [P_NUM_SRC-1:0] pend_vec;
    logic [P_NUM_SRC-1:0] en_vec;
    logic                 irq_act;

    // Event gathering: map the named pulses onto source indices.
    always_comb begin
        ev_vec = '0;
        ev_vec[SRC_UPDATE]   = ev_update;
        ev_vec[SRC_ALARM]    = ev_alarm;
        ev_vec[SRC_PERIODIC] = ev_periodic;
    end

    for (genvar gi = 0; gi < P_NUM_SRC; gi++) begin : g_src
        irq_src_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (ev_vec[gi]),
            .rd_stb (rd_stb),
            .flag_o (flag_vec[gi]),
            .pend_o (pend_vec[gi])
        );
    end

    irq_en_reg #(
        .DATA_W  (P_DATA_W),
        .NUM_SRC (P_NUM_SRC),
        .LSB     (P_FLAG_LSB)
    ) en_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en_o    (en_vec)
    );

    // Request: active while any enabled source holds a flag.
    always_comb irq_act = |(flag_vec & en_vec);

    assign irq_n = ~irq_act;

    irq_status_snap #(
        .DATA_W   (P_DATA_W),
        .NUM_SRC  (P_NUM_SRC),
        .LSB      (P_FLAG_LSB),
        .IRQF_POS (P_IRQF_BIT)
    ) snap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .irq_act (irq_act),
        .flags   (flag_vec),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Module: checker for irq_flag_ctrl, attached with bind. It watches the ports
// plus the enable and pending state.
module irq_flag_ctrl_chk #(
    parameter int NS  = 3,
    parameter int DW  = 8,
    parameter int LSB = 4,
    parameter int IRQ = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] ev_vec,
    input logic [NS-1:0] en_vec,
    input logic [NS-1:0] pend_vec,
    input logic          wr_en,
    input logic          rd_stb,
    input logic [DW-1:0] rd_data,
    input logic          irq_n
);
    AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !wr_en && (|(ev_vec & en_vec))) |=> !irq_n); // R3

    AST_READ_RELEASES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ev_vec == '0 && pend_vec == '0) |=> irq_n); // R5

    AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R6

    AST_IRQF_MIRRORS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[IRQ] == !$past(irq_n))); // R4

    AST_READ_EVENT_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (|ev_vec)) |=> (pend_vec != '0)); // R7

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LSB-1:0] == '0); // R10
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .NS  (P_NUM_SRC),
    .DW  (P_DATA_W),
    .LSB (P_FLAG_LSB),
    .IRQ (P_IRQF_BIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_vec   (ev_vec),
    .en_vec   (en_vec),
    .pend_vec (pend_vec),
    .wr_en    (wr_en),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .irq_n    (irq_n)
);

// File: tb/irq_flag_ctrl_tb_top.sv
// Scoreboard bench. The read driver queues the expected status word and the
// monitor compares it half a cycle after the capturing edge. Inputs change on
// the falling edge.
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_update = 1'b0, ev_alarm = 1'b0, ev_periodic = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_update(ev_update), .ev_alarm(ev_alarm), .ev_periodic(ev_periodic),
        .wr_en(wr_en), .wr_data(wr_data), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    // Field bits per R10: periodic 6, alarm 5, update-ended 4, summary 7.
    localparam logic [7:0] B_PER = 8'h40, B_ALM = 8'h20, B_UPD = 8'h10, B_IRQ = 8'h80;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit u, input bit a, input bit p);
        ev_update = u; ev_alarm = a; ev_periodic = p;
        @(negedge clk);
        ev_update = 0; ev_alarm = 0; ev_periodic = 0;
    endtask

    task automatic write_en(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_read(input logic [7:0] exp, input string req);
        rd_stb = 1'b1;
        exp_q.push_back(exp); req_q.push_back(req);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Monitor: note which edges sampled a read strobe.
    always @(posedge clk) rd_seen <= rd_stb;

    // Monitor: compare the captured status against the scoreboard.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard actual=%02h expected=none", rd_data);
            end else begin
                check(req_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 rd_data", rd_data, 8'h00);

        // R2: polling without enable
        pulse(0, 1, 0);
        check("R2 irq_n stays high", {7'd0, irq_n}, 8'h01);
        do_read(B_ALM, "R2 R10 polled alarm");
        do_read(8'h00, "R5 flags cleared");

        // R3/R4/R5: enabled periodic
        write_en(8'h70);
        pulse(0, 0, 1);
        check("R3 irq_n low", {7'd0, irq_n}, 8'h00);
        do_read(B_IRQ | B_PER, "R4 summary and periodic");
        check("R5 irq_n released", {7'd0, irq_n}, 8'h01);

        // R8: several flags in one read
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        do_read(B_IRQ | B_ALM | B_UPD, "R8 two flags");

        // R6: snapshot held while new events arrive
        pulse(0, 0, 1);
        write_en(8'h70);
        check("R6 snapshot stable", rd_data, B_IRQ | B_ALM | B_UPD);
        do_read(B_IRQ | B_PER, "R6 next read");

        // R7: event on the read cycle
        rd_stb = 1'b1; ev_alarm = 1'b1;
        exp_q.push_back(8'h00); req_q.push_back("R7 event excluded");
        @(negedge clk);
        rd_stb = 1'b0; ev_alarm = 1'b0;
        check("R7 irq_n while pending", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R7 irq_n after merge", {7'd0, irq_n}, 8'h00);
        do_read(B_IRQ | B_ALM, "R7 event reported");

        // R9: late enable of an old flag
        write_en(8'h00);
        pulse(1, 0, 0);
        check("R9 irq_n before enable", {7'd0, irq_n}, 8'h01);
        write_en(B_UPD);
        check("R9 irq_n after enable", {7'd0, irq_n}, 8'h00);
        do_read(B_IRQ | B_UPD, "R9 read");

        // R11: back-to-back read strobes hold the pending event
        write_en(8'h70);
        rd_stb = 1'b1; ev_periodic = 1'b1;
        exp_q.push_back(8'h00); req_q.push_back("R11 first read");
        @(negedge clk);
        ev_periodic = 1'b0;
        exp_q.push_back(8'h00); req_q.push_back("R11 second read");
        @(negedge clk);
        rd_stb = 1'b0;
        check("R11 irq_n during hold", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R11 irq_n after merge", {7'd0, irq_n}, 8'h00);
        do_read(B_IRQ | B_PER, "R11 merged read");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule